// File: doc/BRIEF.md
# Parallel Prefix-Sum Ticket Unit

This block hands out unique, contiguous indices to any group of requesters in a single synchronized step. Each of `N_REQ` requesters raises one bit of a request vector. In the same cycle a logarithmic-depth prefix-count tree works out each active requester's rank. The rank is the number of active requesters at lower lane positions. Each active lane then receives the shared base value plus its rank. The base then moves forward by the number of active requesters, so the next batch continues where this one stopped.

The unit is separate hardware and sits next to the memory network, not inside it. No request ever becomes a memory transaction. A typical use is thread-ID dispatch: worker units ask for the next work item together and get distinct IDs in one step, with no serial atomic increments. A load port places an arbitrary starting value into the base register. A load in the same cycle as a batch takes priority, and that batch is numbered from the loaded value.

Top module: `pfx_ticket_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `grant_vec` all zero, every index lane zero and `base_value` zero.
- R2: `grant_vec` in the cycle after a request cycle equals the request vector of that cycle, so a lane that did not request gets no grant.
- R3: A granted lane i shows the effective base plus the count of requesting lanes with a position lower than i (ascending lane order). The effective base is the load value when `load_en` is high and the stored base otherwise.
- R4: When k lanes request in one cycle, their indices are exactly the k distinct values from effective base to effective base + k − 1, with no gap and no duplicate.
- R5: After each cycle without a load, `base_value` equals its previous value plus the population count of the request vector. An all-zero request vector leaves it unchanged.
- R6: When `load_en` is high, `base_value` becomes `load_value` plus the population count of that cycle's request vector.
- R7: All index and base arithmetic wraps modulo 2^IDX_W (2^32 by default).
- R8: An index lane whose requester was inactive in the previous cycle reads zero.
- R9: Index lane i occupies bits [i*IDX_W +: IDX_W] of `index_flat`. Results appear one cycle after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vec | input | N_REQ | One request bit per requester |
| load_en | input | 1 | Load the base register this cycle |
| load_value | input | IDX_W | Value to load into the base |
| grant_vec | output | N_REQ | Registered grant per lane, one cycle after the request |
| index_flat | output | N_REQ*IDX_W | Registered index per lane, lane i at [i*IDX_W +: IDX_W] |
| base_value | output | IDX_W | Current base register |

## Verification
The bench builds the unit with six requesters and the default 32-bit base. At that size all 64 request masks can be swept one after another, so every rank pattern the prefix tree can produce is checked against a count done in the bench. Loads placed just below 2^32 bring the wrap of both the indices and the base within reach. Loads combined with all-zero and all-ones masks exercise the priority of a load over the stored base.

// File: rtl/pfx_pkg.sv
// Package: shared helpers for the prefix-sum ticket unit.
// Assumes: widths are derived from the requester count at elaboration.
package pfx_pkg;
    // Bits needed to hold a count from 0 to n inclusive.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Number of doubling levels in a prefix tree over n lanes.
    function automatic int unsigned tree_levels(input int unsigned n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction
endpackage

// File: rtl/pfx_scan_tree.sv
// Module: pfx_scan_tree
// Computes, over a one-bit request vector, each lane's exclusive prefix
// count (its rank among active lanes in ascending order) and the total.
// It is built as a Kogge-Stone tree of tree_levels(N) doubling levels.
// Assumes: purely combinational; CW is wide enough to hold N.
module pfx_scan_tree #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = 5
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0][CW-1:0] rank,
    output logic [CW-1:0]        total
);
    localparam int unsigned LV = pfx_pkg::tree_levels(N);

    logic [N-1:0][CW-1:0] stage [LV+1];

    genvar gi, gl;
    generate
        // Seed level: each lane counts itself.
        for (gi = 0; gi < N; gi++) begin : g_seed
            assign stage[0][gi] = CW'(req[gi]);
        end
        // Doubling levels: add the partial sum 2^l lanes below.
        for (gl = 0; gl < LV; gl++) begin : g_lvl
            for (gi = 0; gi < N; gi++) begin : g_lane
                if (gi >= (1 << gl)) begin : g_add
                    assign stage[gl+1][gi] = stage[gl][gi] + stage[gl][gi - (1 << gl)];
                end else begin : g_pass
                    assign stage[gl+1][gi] = stage[gl][gi];
                end
            end
        end
        // Exclusive rank: remove the lane's own contribution.
        for (gi = 0; gi < N; gi++) begin : g_rank
            assign rank[gi] = stage[LV][gi] - CW'(req[gi]);
        end
    endgenerate

    assign total = stage[LV][N-1];

    // Cross-check the tree total against a direct population count.
    always_comb begin
        // R5
        total_count_chk: assert (32'(total) == 32'($countones(req)));
    end
endmodule

// File: rtl/pfx_base_reg.sv
// Module: pfx_base_reg
// Holds the shared base. It picks the effective base for the current batch
// (the load value wins over the stored base) and advances it by the batch size.
// Assumes: arithmetic wraps modulo 2^W; synchronous active-low reset to zero.
module pfx_base_reg #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [W-1:0]  load_value,
    input  logic [CW-1:0] advance,
    output logic [W-1:0]  eff_base,
    output logic [W-1:0]  base_q
);
    // Select the base this batch is numbered from.
    always_comb begin
        eff_base = load_en ? load_value : base_q;
    end

    // Store the base for the next batch.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= eff_base + W'(advance);
    end

    // R6
    load_takes_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_en)) |-> (base_q == $past(load_value) + W'($past(advance))));
endmodule

// File: rtl/pfx_issue_stage.sv
// Module: pfx_issue_stage
// Adds each lane's rank to the effective base and registers grants and
// indices. Lanes that did not request get a zero index and no grant.
// Assumes: rank and eff_base are valid in the request cycle.
module pfx_issue_stage #(
    parameter int unsigned N  = 16,
    parameter int unsigned W  = 32,
    parameter int unsigned CW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic [N-1:0][CW-1:0] rank,
    input  logic [W-1:0]         eff_base,
    output logic [N-1:0]         grant_q,
    output logic [N-1:0][W-1:0]  index_q
);
    logic [N-1:0][W-1:0] index_d;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_lane
            // Form this lane's index, or zero when the lane is idle.
            always_comb begin
                index_d[gi] = req[gi] ? (eff_base + W'(rank[gi])) : '0;
            end

            // R8
            idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !grant_q[gi] |-> (index_q[gi] == '0));
        end
    endgenerate

    // Register the grants and indices of the batch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            index_q <= '0;
        end else begin
            grant_q <= req;
            index_q <= index_d;
        end
    end

    // R3
    lowest_lane_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && grant_q[0]) |-> (index_q[0] == $past(eff_base)));
endmodule

// File: rtl/pfx_ticket_unit.sv
// Module: pfx_ticket_unit (top)
// Synchronized fetch-and-increment unit: every active requester receives
// base + rank in one step, and the base advances by the number served.
// Assumes: synchronous active-low reset; results are valid one cycle
// after the request cycle.
module pfx_ticket_unit #(
    parameter int unsigned N_REQ = 16,
    parameter int unsigned IDX_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_REQ-1:0]         req_vec,
    input  logic                     load_en,
    input  logic [IDX_W-1:0]         load_value,
    output logic [N_REQ-1:0]         grant_vec,
    output logic [N_REQ*IDX_W-1:0]   index_flat,
    output logic [IDX_W-1:0]         base_value
);
    localparam int unsigned CW = pfx_pkg::cnt_width(N_REQ);

    logic [N_REQ-1:0][CW-1:0]    rank;
    logic [CW-1:0]               total;
    logic [IDX_W-1:0]            eff_base;
    logic [N_REQ-1:0][IDX_W-1:0] index_q;

    pfx_scan_tree #(.N(N_REQ), .CW(CW)) u_scan (
        .req   (req_vec),
        .rank  (rank),
        .total (total)
    );

    pfx_base_reg #(.W(IDX_W), .CW(CW)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_value (load_value),
        .advance    (total),
        .eff_base   (eff_base),
        .base_q     (base_value)
    );

    pfx_issue_stage #(.N(N_REQ), .W(IDX_W), .CW(CW)) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_vec),
        .rank     (rank),
        .eff_base (eff_base),
        .grant_q  (grant_vec),
        .index_q  (index_q)
    );

    assign index_flat = index_q;

    // R2
    grant_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (grant_vec == $past(req_vec)));

    // R5
    base_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_en)) |->
            (base_value == $past(base_value) + IDX_W'($countones($past(req_vec)))));
endmodule

// File: tb/pfx_ticket_unit_bench.sv
// Bench: exhaustive mask sweep over a six-lane build plus load and wrap cases.
module pfx_ticket_unit_bench;
    localparam int unsigned N = 6;
    localparam int unsigned W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     req_vec = '0;
    logic             load_en = 1'b0;
    logic [W-1:0]     load_value = '0;
    logic [N-1:0]     grant_vec;
    logic [N*W-1:0]   index_flat;
    logic [W-1:0]     base_value;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] exp_base = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    pfx_ticket_unit #(.N_REQ(N), .IDX_W(W)) u_pfx_ticket_unit (
        .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .load_en(load_en),
        .load_value(load_value), .grant_vec(grant_vec),
        .index_flat(index_flat), .base_value(base_value)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one batch, then check grants, every lane, contiguity and the base.
    task automatic batch(input logic [N-1:0] mask, input logic ld, input logic [W-1:0] ldv);
        logic [W-1:0] eff;
        logic [W-1:0] lane;
        logic [W-1:0] seen;
        int k;
        int rank;
        int dup;
        @(negedge clk);
        req_vec = mask; load_en = ld; load_value = ldv;
        eff = ld ? ldv : exp_base;
        k = $countones(mask);
        @(posedge clk); #1;
        req_vec = '0; load_en = 1'b0;
        check("R2 grant", W'(grant_vec), W'(mask));
        seen = '0; dup = 0;
        for (int i = 0; i < N; i++) begin
            lane = index_flat[i*W +: W];
            if (mask[i]) begin
                rank = 0;
                for (int j = 0; j < i; j++) rank += int'(mask[j]);
                check("R3 R7 R9 lane index", lane, eff + W'(rank));
                if ((lane - eff) < W'(N)) begin
                    if (seen[lane - eff]) dup = 1;
                    seen[lane - eff] = 1'b1;
                end
            end else begin
                check("R8 idle lane", lane, '0);
            end
        end
        check("R4 contiguous set", seen | W'(dup << 31), (W'(1) << k) - W'(1));
        exp_base = eff + W'(k);
        check(ld ? "R6 R7 base after load" : "R5 R7 base advance", base_value, exp_base);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        req_vec = '1; load_en = 1'b1; load_value = 32'h1234;
        @(posedge clk); #1;
        check("R1 grant reset", W'(grant_vec), '0);
        check("R1 index reset", index_flat[W-1:0] | index_flat[N*W-1 -: W], '0);
        check("R1 base reset", base_value, '0);
        @(negedge clk);
        req_vec = '0; load_en = 1'b0;
        rst_n = 1'b1;
        exp_base = '0;
        // Exhaustive sweep of all masks.
        for (int m = 0; m < (1 << N); m++) batch(N'(m), 1'b0, '0);
        // Zero mask leaves the base (R5); load with zero mask (R6).
        batch('0, 1'b0, '0);
        batch('0, 1'b1, 32'h0000_0100);
        // Wrap near 2^32 with a load and all lanes active (R7).
        batch('1, 1'b1, 32'hFFFF_FFFD);
        batch('1, 1'b0, '0);
        // Load and batch in same cycle with sparse masks (R6).
        batch(6'b101010, 1'b1, 32'h8000_0000);
        batch(6'b010101, 1'b0, '0);
        // Pseudo-random masks with occasional loads.
        for (int r = 0; r < 300; r++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            batch(lfsr[N-1:0], lfsr[15] & lfsr[9] & lfsr[7], {lfsr, ~lfsr});
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule